// File: doc/BRIEF.md
# Serial Non-Volatile Memory Target on a Four-Wire Synchronous Bus

This block models a small serial non-volatile memory that a bus master reaches over four wires: a select, a serial clock, a serial data input and a serial data output. The array holds 64 words of 16 bits. When the organisation input is low, the same storage is seen as 128 bytes instead. Every transfer is a frame. A frame opens with a start bit, carries a two-bit opcode and an address, and for the two data-writing commands it also carries a data field. Seven commands are decoded. When the opcode is zero, the top two address bits pick which of the four extra commands runs.

The serial clock, select and data input are all sampled by a fast system clock. Commands that modify the array are held back by a write-enable latch. They are only committed after the master lowers select. A self-timed programming cycle then runs for a parameterised number of system clocks. If the master raises select while that cycle is running, the output line shows a ready/busy flag.

Top module: `mw_eeprom_model`

## Requirements
- R1: After reset the data output is not driven, the write-enable latch is clear and every word reads as all ones.
- R2: While select is low, serial clock and data input have no effect and the output is not driven. Lowering select in the middle of a frame abandons that frame.
- R3: Zeros clocked in before the first 1 are ignored, and that first 1 is the start bit.
- R4: Bits are taken on rising serial clock edges. After the start bit come a 2-bit opcode and an address, both MSB first. The address is 6 bits when organisation is high and 7 bits when it is low.
- R5: Opcode 10 reads. On the rising edge of the last address bit the output drives a dummy 0. Each following rising edge then shifts out the next data bit, MSB first.
- R6: In byte mode, byte address bit 0 = 0 selects bits 7:0 of word address[6:1], and bit 0 = 1 selects bits 15:8.
- R7: Opcode 00 with address MSBs 11 sets the write-enable latch, and 00 with MSBs 00 clears it. While the latch is clear, write, erase, write-all and erase-all start no programming cycle and leave the array unchanged.
- R8: Opcode 01 followed by a data field (16 or 8 bits, MSB first) replaces the addressed location without a prior erase. The new value is committed when the programming cycle triggered by select falling completes.
- R9: Opcode 11 sets the addressed location to all ones. Opcode 00 with MSBs 10 sets the whole array to all ones.
- R10: Opcode 00 with MSBs 01 followed by a data field writes that value to every location. In byte mode the byte is written to both halves of every word.
- R11: During a programming cycle, raising select drives 0 on the output. The output becomes 1 no earlier than PROG_CYCLES clocks after select fell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Bus select, active high |
| sk | input | 1 | Serial bus clock |
| di | input | 1 | Serial data from the master |
| org | input | 1 | Organisation: 1 = 16-bit words, 0 = 8-bit bytes |
| do_o | output | 1 | Serial data or ready/busy flag toward the master |
| do_oe | output | 1 | Output enable for do_o; low means high impedance |

## Verification
The hardest case to reach from the ports is the window where a programming cycle is running and the master raises select to poll for completion. The bench lowers select right after a write-type frame and raises it again a few clocks later. It first checks for the busy 0 on the output. It then counts system clocks until the output flips to 1 and compares that count with the configured programming length. The locked case is reached the same way: a write-type frame is sent with the latch clear, and the bench checks that raising select afterwards gives an undriven output and that the array still reads unchanged.

// File: rtl/mw_eeprom_model.sv
`timescale 1ns/1ps
module mw_eeprom_model #(
  parameter int WORDS       = 64,
  parameter int WBITS       = 16,
  parameter int PROG_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  input  logic org,
  output logic do_o,
  output logic do_oe
);
  localparam int AW    = $clog2(WORDS);
  localparam int BBITS = WBITS / 2;
  localparam int CW    = $clog2(WBITS + AW + 4);
  localparam int TW    = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_START, S_HDR, S_DATA, S_READ, S_SKIP} st_t;
  typedef enum logic [1:0] {P_WR, P_ER, P_WA, P_EA} pk_t;

  logic [2:0] cs_r, sk_r;
  logic [1:0] di_r;
  logic       cs_s, cs_d, di_s, sk_rise, cs_fall, cs_rise;

  logic [WBITS-1:0] mem [WORDS];

  st_t             st;
  pk_t             pkind;
  logic [CW-1:0]   cnt;
  logic [1:0]      op;
  logic [AW-1:0]   addr;
  logic [WBITS-1:0] dat, out_sr;
  logic            do_q, wen, pend, busy, stat;
  logic [TW-1:0]   tmr;
  logic [AW-1:0]   tgt_w;
  logic            tgt_b, tgt_x16;

  logic [AW:0]     a_full;
  logic [AW-1:0]   widx;
  logic [1:0]      msb2;
  logic            hdr_last, dat_last, commit;
  logic [WBITS-1:0] rd_word, rd_load;

  assign cs_s    = cs_r[1];
  assign cs_d    = cs_r[2];
  assign di_s    = di_r[1];
  assign sk_rise = sk_r[1] & ~sk_r[2];
  assign cs_fall = cs_d & ~cs_s;
  assign cs_rise = cs_s & ~cs_d;

  assign a_full   = {addr, di_s};
  assign widx     = org ? a_full[AW-1:0] : a_full[AW:1];
  assign msb2     = org ? a_full[AW-1:AW-2] : a_full[AW:AW-1];
  assign hdr_last = (cnt == (org ? CW'(AW + 1) : CW'(AW + 2)));
  assign dat_last = (cnt == (tgt_x16 ? CW'(WBITS - 1) : CW'(BBITS - 1)));
  assign rd_word  = mem[widx];
  assign rd_load  = org ? rd_word
                        : {(a_full[0] ? rd_word[WBITS-1:BBITS] : rd_word[BBITS-1:0]), {BBITS{1'b0}}};
  assign commit   = busy && (tmr == TW'(1));

  assign do_oe = cs_s & ((st == S_READ) | stat);
  assign do_o  = (st == S_READ) ? do_q : ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_r    <= '0;
      sk_r    <= '0;
      di_r    <= '0;
      st      <= S_START;
      pkind   <= P_WR;
      cnt     <= '0;
      op      <= '0;
      addr    <= '0;
      dat     <= '0;
      out_sr  <= '0;
      do_q    <= 1'b0;
      wen     <= 1'b0;
      pend    <= 1'b0;
      busy    <= 1'b0;
      stat    <= 1'b0;
      tmr     <= '0;
      tgt_w   <= '0;
      tgt_b   <= 1'b0;
      tgt_x16 <= 1'b1;
    end else begin
      cs_r <= {cs_r[1:0], cs};
      sk_r <= {sk_r[1:0], sk};
      di_r <= {di_r[0], di};

      if (commit) busy <= 1'b0;
      else if (busy) tmr <= tmr - TW'(1);

      if (cs_rise) stat <= busy;

      if (cs_fall) begin
        st   <= S_START;
        cnt  <= '0;
        stat <= 1'b0;
        if (pend) begin
          busy <= 1'b1;
          tmr  <= TW'(PROG_CYCLES);
          pend <= 1'b0;
        end
      end else if (sk_rise && cs_s && !busy) begin
        case (st)
          S_START: if (di_s) begin
            st   <= S_HDR;
            cnt  <= '0;
            stat <= 1'b0;
          end
          S_HDR: begin
            cnt <= cnt + CW'(1);
            if (cnt < CW'(2)) op <= {op[0], di_s};
            else              addr <= {addr[AW-2:0], di_s};
            if (hdr_last) begin
              cnt     <= '0;
              tgt_w   <= widx;
              tgt_b   <= a_full[0];
              tgt_x16 <= org;
              st      <= S_SKIP;
              case (op)
                2'b10: begin
                  out_sr <= rd_load;
                  do_q   <= 1'b0;
                  st     <= S_READ;
                end
                2'b01: if (wen) begin
                  pkind <= P_WR;
                  st    <= S_DATA;
                end
                2'b11: if (wen) begin
                  pkind <= P_ER;
                  pend  <= 1'b1;
                end
                default: case (msb2)
                  2'b11: wen <= 1'b1;
                  2'b00: wen <= 1'b0;
                  2'b01: if (wen) begin
                    pkind <= P_WA;
                    st    <= S_DATA;
                  end
                  default: if (wen) begin
                    pkind <= P_EA;
                    pend  <= 1'b1;
                  end
                endcase
              endcase
            end
          end
          S_DATA: begin
            dat <= {dat[WBITS-2:0], di_s};
            cnt <= cnt + CW'(1);
            if (dat_last) begin
              pend <= 1'b1;
              st   <= S_SKIP;
            end
          end
          S_READ: begin
            do_q   <= out_sr[WBITS-1];
            out_sr <= {out_sr[WBITS-2:0], 1'b0};
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '1;
    end else if (commit) begin
      case (pkind)
        P_WR, P_ER: begin
          if (tgt_x16)    mem[tgt_w] <= (pkind == P_WR) ? dat : '1;
          else if (tgt_b) mem[tgt_w][WBITS-1:BBITS] <= (pkind == P_WR) ? dat[BBITS-1:0] : '1;
          else            mem[tgt_w][BBITS-1:0]     <= (pkind == P_WR) ? dat[BBITS-1:0] : '1;
        end
        P_WA: for (int i = 0; i < WORDS; i++)
                mem[i] <= tgt_x16 ? dat : {dat[BBITS-1:0], dat[BBITS-1:0]};
        default: for (int i = 0; i < WORDS; i++) mem[i] <= '1;
      endcase
    end
  end
endmodule

module mw_eeprom_checker (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic cs_s,
  input logic do_o,
  input logic do_oe,
  input logic busy,
  input logic wen
);
  AST_HIZ_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && !$past(cs) && !$past(cs, 2)) |-> !do_oe); // R2
  AST_BUSY_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && do_oe) |-> !do_o); // R11
  AST_LOCKED_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> !$rose(busy)); // R7
  AST_PROG_AFTER_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !cs_s); // R8
  AST_DO_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    do_oe |-> !$isunknown(do_o)); // R5
endmodule

bind mw_eeprom_model mw_eeprom_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .cs_s(cs_s),
  .do_o(do_o), .do_oe(do_oe), .busy(busy), .wen(wen)
);

// File: tb/test_mw_eeprom_model.sv
`timescale 1ns/1ps
module test_mw_eeprom_model;
  localparam int HALF = 6;
  localparam int PROG = 400;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, org = 1'b1;
  logic do_o, do_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mw_eeprom_model #(.PROG_CYCLES(PROG)) i_mw_eeprom_model (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
    .do_o(do_o), .do_oe(do_oe)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic b, output logic s);
    di = b;
    tick(HALF);
    sk = 1'b1;
    tick(HALF);
    s  = do_o;
    sk = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] v, input int n, input int nrd,
                      output logic dummy, output logic [15:0] rd);
    logic s;
    cs = 1'b1;
    tick(HALF);
    dummy = 1'b1;
    for (int i = n - 1; i >= 0; i--) begin
      pulse(v[i], s);
      dummy = s;
    end
    rd = '0;
    for (int k = 0; k < nrd; k++) begin
      pulse(1'b0, s);
      rd = {rd[14:0], s};
    end
    tick(2);
    cs = 1'b0;
    tick(HALF);
  endtask

  task automatic wait_prog(input bit expect_busy, input string req);
    int el;
    el = HALF;
    cs = 1'b1;
    tick(4);
    el += 4;
    if (expect_busy) begin
      chk(do_oe === 1'b1 && do_o === 1'b0, {req, " R11 busy flag"}, {do_oe, do_o}, 2'b10);
      while (do_o !== 1'b1 && el < PROG + 60) begin
        tick(1);
        el++;
      end
      chk(el >= PROG && el <= PROG + 20, {req, " R11 ready time"}, el, PROG);
    end else begin
      chk(do_oe === 1'b0, {req, " R7 no programming"}, do_oe, 0);
    end
    cs = 1'b0;
    tick(HALF);
  endtask

  task automatic rd16(input logic [5:0] a, input string req, input logic [15:0] exp);
    logic d; logic [15:0] r;
    xfer({23'b0, 1'b1, 2'b10, a}, 9, 16, d, r);
    chk(d === 1'b0, {req, " R5 dummy bit"}, d, 0);
    chk(r === exp, {req, " R5 read word"}, r, exp);
  endtask

  task automatic rd8(input logic [6:0] a, input string req, input logic [7:0] exp);
    logic d; logic [15:0] r;
    xfer({22'b0, 1'b1, 2'b10, a}, 10, 8, d, r);
    chk(d === 1'b0 && r[7:0] === exp, {req, " R6 read byte"}, r[7:0], exp);
  endtask

  task automatic cmd(input logic [31:0] v, input int n);
    logic d; logic [15:0] r;
    xfer(v, n, 0, d, r);
  endtask

  task automatic ewen(); cmd({23'b0, 1'b1, 2'b00, 2'b11, 4'b0}, 9); endtask
  task automatic ewds(); cmd({23'b0, 1'b1, 2'b00, 2'b00, 4'b0}, 9); endtask

  task automatic t_reset();
    chk(do_oe === 1'b0, "R1 output idle", do_oe, 0);
    rd16(6'd5, "R1 erased after reset", 16'hFFFF);
  endtask

  task automatic t_cs_low();
    logic s;
    cs = 1'b0;
    for (int i = 8; i >= 0; i--) begin
      pulse(((9'b1_00_11_0000 >> i) & 1) != 0, s);
      chk(do_oe === 1'b0, "R2 undriven while deselected", do_oe, 0);
    end
    cmd({7'b0, 1'b1, 2'b01, 6'd3, 16'h1234}, 25);
    wait_prog(1'b0, "R2 enable sent while deselected");
    rd16(6'd3, "R2 R7 locked write", 16'hFFFF);
    cs = 1'b1; tick(HALF);
    pulse(1'b1, s); pulse(1'b0, s);
    cs = 1'b0; tick(HALF);
    rd16(6'd3, "R2 aborted frame", 16'hFFFF);
  endtask

  task automatic t_lead_zero();
    logic d; logic [15:0] r;
    xfer({18'b0, 5'b00000, 1'b1, 2'b10, 6'd7}, 14, 16, d, r);
    chk(d === 1'b0 && r === 16'hFFFF, "R3 leading zeros", r, 16'hFFFF);
  endtask

  task automatic t_write16();
    ewen();
    cmd({7'b0, 1'b1, 2'b01, 6'd10, 16'hA5C3}, 25);
    wait_prog(1'b1, "R8 write");
    rd16(6'd10, "R8 R4 write word", 16'hA5C3);
    cmd({7'b0, 1'b1, 2'b01, 6'd10, 16'h0F0F}, 25);
    wait_prog(1'b1, "R8 overwrite");
    rd16(6'd10, "R8 overwrite without erase", 16'h0F0F);
    rd16(6'd11, "R8 neighbour untouched", 16'hFFFF);
    cmd({23'b0, 1'b1, 2'b11, 6'd10}, 9);
    wait_prog(1'b1, "R9 erase");
    rd16(6'd10, "R9 erase word", 16'hFFFF);
  endtask

  task automatic t_byte();
    org = 1'b0;
    tick(2);
    cmd({14'b0, 1'b1, 2'b01, 7'd21, 8'h3C}, 18);
    wait_prog(1'b1, "R6 byte write");
    rd8(7'd21, "R6 high byte", 8'h3C);
    rd8(7'd20, "R6 low byte", 8'hFF);
    org = 1'b1;
    tick(2);
    rd16(6'd10, "R6 word view", 16'h3CFF);
  endtask

  task automatic t_lock();
    ewds();
    cmd({7'b0, 1'b1, 2'b01, 6'd10, 16'h0000}, 25);
    wait_prog(1'b0, "R7 write after disable");
    cmd({23'b0, 1'b1, 2'b00, 2'b10, 4'b0}, 9);
    wait_prog(1'b0, "R7 erase-all after disable");
    rd16(6'd10, "R7 locked array", 16'h3CFF);
  endtask

  task automatic t_all();
    ewen();
    cmd({7'b0, 1'b1, 2'b00, 2'b01, 4'b0, 16'h1357}, 25);
    wait_prog(1'b1, "R10 write-all");
    rd16(6'd0, "R10 first word", 16'h1357);
    rd16(6'd63, "R10 last word", 16'h1357);
    org = 1'b0;
    tick(2);
    cmd({14'b0, 1'b1, 2'b00, 2'b01, 5'b0, 8'h6A}, 18);
    wait_prog(1'b1, "R10 byte write-all");
    org = 1'b1;
    tick(2);
    rd16(6'd40, "R10 byte fill both halves", 16'h6A6A);
    cmd({23'b0, 1'b1, 2'b00, 2'b10, 4'b0}, 9);
    wait_prog(1'b1, "R9 erase-all");
    rd16(6'd0, "R9 erase-all first", 16'hFFFF);
    rd16(6'd63, "R9 erase-all last", 16'hFFFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_cs_low();
    t_lead_zero();
    t_write16();
    t_byte();
    t_lock();
    t_all();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule